// File: doc/BRIEF.md
# Serial Flash Hold Gate

This block sits between the pins of a serial flash slave and the shift logic behind them. It provides the pause function. While the hold pin is low, the command in progress is frozen. The data output is released to high impedance. Serial clock edges and data input values are ignored, so bit counters and shift registers keep their contents.

All pins are oversampled by a faster system clock. Each pin passes through a synchroniser of `SYNC_STAGES` flip-flops. Serial clock edges are found by comparing successive synchronised samples. The internal logic receives one enable pulse per rising serial clock edge and one per falling edge. The captured data input bit comes with the rising-edge pulse.

A change on the hold pin takes effect only while the serial clock is low. If the serial clock is high when hold changes, the change waits until the clock next goes low.

If chip select is released while the block is held, the block asks the command logic to reset. It then ignores the bus until hold has been high during a deselected period. Only after that can chip select start a new command.

Top module: `spi_hold_gate`

## Requirements
- R1: While selected (chip select low) and not held, each rising serial clock edge gives exactly one `shift_en` pulse, and `si_bit` carries the data input value sampled with that edge. Bits sent MSB first reassemble into the byte sent.
- R2: While selected and not held, each falling serial clock edge gives exactly one `shift_fall_en` pulse.
- R3: A low hold pin with the serial clock low sets `hold_active` within SYNC_STAGES+2 system clocks.
- R4: A low hold pin with the serial clock high does not set `hold_active`. `hold_active` is set only once the serial clock next goes low, and the falling edge that causes it gives no `shift_fall_en` pulse.
- R5: Release of hold ends `hold_active` at once if the serial clock is low. If the serial clock is high, `hold_active` stays set until the clock next goes low.
- R6: While `hold_active` is 1, `so_oe` is 0 whatever `so_oe_int` is.
- R7: While `hold_active` is 1, serial clock edges give no `shift_en` or `shift_fall_en` pulse. A byte interrupted by a hold and completed afterwards is received intact.
- R8: Chip select going high while held clears `hold_active` and gives a single-cycle `cmd_reset` pulse.
- R9: After R8, the block stays locked out. While locked out, chip select low with hold low neither sets `hold_active` nor produces shift pulses. The lockout ends only after hold is high while chip select is high. A following chip select low then works normally.
- R10: `so_oe` is 0 while chip select is high. While selected and not held or locked out, `so_oe` follows `so_oe_int`, and `so_out` follows `so_int`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| si_pin | input | 1 | Serial data input pin |
| so_int | input | 1 | Data output value from the internal logic |
| so_oe_int | input | 1 | Output enable requested by the internal logic |
| shift_en | output | 1 | One-cycle pulse per accepted rising serial clock edge |
| shift_fall_en | output | 1 | One-cycle pulse per accepted falling serial clock edge |
| si_bit | output | 1 | Synchronised data input, valid with `shift_en` |
| so_out | output | 1 | Data output value to the pad |
| so_oe | output | 1 | Tri-state enable for the data output pad |
| cmd_reset | output | 1 | One-cycle reset request to the command logic |
| hold_active | output | 1 | High while the hold state is in force |

## Verification
A wrong held flag shows up at the ports within a few system clocks. It appears as `hold_active` rising or falling while the serial clock is high, or as `so_oe` staying driven during a pause. A wrongly gated edge is harder to spot: it only shows as a bit count off by one, or as a corrupted byte once the interrupted transfer finishes. For that reason the bench reassembles whole bytes across a pause. A lockout that clears too early or never shows up the first time chip select drops after a reset: pulses appear with hold still low, or never appear after a proper restart.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic hold_n_pin,
  input  logic si_pin,
  input  logic so_int,
  input  logic so_oe_int,
  output logic shift_en,
  output logic shift_fall_en,
  output logic si_bit,
  output logic so_out,
  output logic so_oe,
  output logic cmd_reset,
  output logic hold_active
);
  // pin bus order: {cs, hold, sck, si}
  localparam logic [3:0] PIN_IDLE = 4'b1100;
  localparam int LAST = SYNC_STAGES - 1;

  logic [3:0] sync_q [SYNC_STAGES];
  logic cs_s, hold_s, sck_s, si_s;
  logic sck_prev, held, locked;
  logic held_nx, locked_nx, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= PIN_IDLE;
    end else begin
      sync_q[0] <= {cs_n_pin, hold_n_pin, sck_pin, si_pin};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {cs_s, hold_s, sck_s, si_s} = sync_q[LAST];

  always_comb begin
    if (cs_s || locked) held_nx = 1'b0;
    else if (!sck_s)    held_nx = !hold_s;
    else                held_nx = held;
  end

  always_comb begin
    if (cs_s && held)        locked_nx = 1'b1;
    else if (cs_s && hold_s) locked_nx = 1'b0;
    else                     locked_nx = locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev  <= 1'b0;
      held      <= 1'b0;
      locked    <= 1'b0;
      cmd_reset <= 1'b0;
    end else begin
      sck_prev  <= sck_s;
      held      <= held_nx;
      locked    <= locked_nx;
      cmd_reset <= cs_s && held;
    end
  end

  assign live          = !cs_s && !locked && !held && !held_nx;
  assign shift_en      = live && sck_s && !sck_prev;
  assign shift_fall_en = live && !sck_s && sck_prev;
  assign si_bit        = si_s;
  assign so_out        = so_int;
  assign so_oe         = so_oe_int && !cs_s && !held && !locked;
  assign hold_active   = held;

  p_enter_sck_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> !$past(sck_s));

  p_exit_sck_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_active) && !$past(cs_s)) |-> !$past(sck_s));

  p_oe_off_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !so_oe);

  p_no_shift_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !(shift_en || shift_fall_en));

  p_reset_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!cmd_reset && !hold_active && locked));

  p_locked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !(hold_active || shift_en || shift_fall_en || so_oe));

  p_deselect_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !so_oe);
endmodule

// File: tb/tb_spi_hold_gate.sv
module tb_spi_hold_gate;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n_pin = 1'b1, sck_pin = 1'b0, hold_n_pin = 1'b1, si_pin = 1'b0;
  logic so_int = 1'b1, so_oe_int = 1'b1;
  logic shift_en, shift_fall_en, si_bit, so_out, so_oe, cmd_reset, hold_active;

  int n_checks = 0, n_fails = 0;
  int rises = 0, falls = 0, resets = 0;
  logic [7:0] rx = 8'h00;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_gate #(.SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
    .hold_n_pin(hold_n_pin), .si_pin(si_pin), .so_int(so_int), .so_oe_int(so_oe_int),
    .shift_en(shift_en), .shift_fall_en(shift_fall_en), .si_bit(si_bit),
    .so_out(so_out), .so_oe(so_oe), .cmd_reset(cmd_reset), .hold_active(hold_active));

  always @(negedge clk) begin
    if (shift_en) begin rises++; rx = {rx[6:0], si_bit}; end
    if (shift_fall_en) falls++;
    if (cmd_reset) resets++;
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck_pin = 1'b1; idle(HALF_SCK);
    sck_pin = 1'b0; idle(HALF_SCK);
  endtask

  task automatic send_bits(logic [7:0] b, int first, int last);
    for (int i = first; i >= last; i--) begin
      si_pin = b[i]; idle(HALF_SCK);
      sck_pulse();
    end
  endtask

  task automatic t_reset();
    chk("R10 reset so_oe", so_oe, 0);
    chk("R3 reset hold_active", hold_active, 0);
    chk("R8 reset cmd_reset", cmd_reset, 0);
    chk("R1 reset shift_en", shift_en, 0);
  endtask

  task automatic t_plain_byte();
    cs_n_pin = 1'b0; idle(6);
    chk("R10 selected so_oe", so_oe, 1);
    chk("R10 so_out follows", so_out, 1);
    rises = 0; falls = 0;
    send_bits(8'hA5, 7, 0); idle(4);
    chk("R1 rise count", rises, 8);
    chk("R1 byte", rx, 8'hA5);
    chk("R2 fall count", falls, 8);
    so_oe_int = 1'b0; idle(1);
    chk("R10 so_oe follows request", so_oe, 0);
    so_oe_int = 1'b1;
    cs_n_pin = 1'b1; idle(6);
    chk("R10 deselected so_oe", so_oe, 0);
  endtask

  task automatic t_hold_mid_byte();
    cs_n_pin = 1'b0; idle(6);
    rises = 0; falls = 0;
    send_bits(8'hC3, 7, 4);
    hold_n_pin = 1'b0; idle(4);
    chk("R3 immediate entry", hold_active, 1);
    chk("R6 oe off while held", so_oe, 0);
    for (int k = 0; k < 3; k++) begin si_pin = k[0]; sck_pulse(); end
    chk("R7 no rises held", rises, 4);
    chk("R7 no falls held", falls, 4);
    hold_n_pin = 1'b1; idle(4);
    chk("R5 immediate exit", hold_active, 0);
    chk("R10 oe back after hold", so_oe, 1);
    send_bits(8'hC3, 3, 0); idle(4);
    chk("R7 resumed byte", rx, 8'hC3);
    chk("R1 total rises", rises, 8);
    cs_n_pin = 1'b1; idle(6);
  endtask

  task automatic t_deferred();
    cs_n_pin = 1'b0; idle(6);
    falls = 0;
    sck_pin = 1'b1; idle(6);
    hold_n_pin = 1'b0; idle(8);
    chk("R4 no entry while sck high", hold_active, 0);
    sck_pin = 1'b0; idle(5);
    chk("R4 entry at sck low", hold_active, 1);
    chk("R4 entering fall suppressed", falls, 0);
    sck_pin = 1'b1; idle(6);
    hold_n_pin = 1'b1; idle(8);
    chk("R5 no exit while sck high", hold_active, 1);
    sck_pin = 1'b0; idle(5);
    chk("R5 exit at sck low", hold_active, 0);
    cs_n_pin = 1'b1; idle(6);
  endtask

  task automatic t_deselect_in_hold();
    cs_n_pin = 1'b0; idle(6);
    hold_n_pin = 1'b0; idle(5);
    chk("R3 held before deselect", hold_active, 1);
    resets = 0;
    cs_n_pin = 1'b1; idle(6);
    chk("R8 one reset pulse", resets, 1);
    chk("R8 hold cleared", hold_active, 0);
    cs_n_pin = 1'b0; idle(6);
    rises = 0;
    chk("R9 no re-entry", hold_active, 0);
    chk("R9 oe off locked", so_oe, 0);
    sck_pulse(); sck_pulse();
    chk("R9 no shifts locked", rises, 0);
    hold_n_pin = 1'b1; idle(6);
    cs_n_pin = 1'b1; idle(6);
    cs_n_pin = 1'b0; idle(6);
    send_bits(8'h5A, 7, 0); idle(4);
    chk("R9 restart rises", rises, 8);
    chk("R9 restart byte", rx, 8'h5A);
    cs_n_pin = 1'b1; idle(6);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_plain_byte();
    t_hold_mid_byte();
    t_deferred();
    t_deselect_in_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule